// File: doc/BRIEF.md
# Retention Latch Result Cache

This block is a small, fully associative store for recently produced results. It serves a reorder buffer that has lost its operand read ports. Each result that is written back is also captured here, together with the reorder-buffer tag of the instruction that produced it. Instructions being dispatched present their source tags on one of several lookup ports and get the value back in the same cycle. When the value is not present, the lookup reports a miss. The instruction must then wait for the value to be broadcast a second time, when its entry retires into the architectural register file.

Each latch holds one 32-bit (single-precision) word. A 64-bit (double-precision) result fills two latches in one write cycle: the low word goes into the first latch and the high word into the next one. Latches are reused in strict age order, so the oldest latch is overwritten first. Retirement of a tag removes that tag's latches. A pipeline flush empties the whole store. A lookup whose tag is being written in the same cycle is answered directly from the write-back inputs.

Top module: `rlat_cache`

## Requirements
- R1: After reset no latch is valid, so every lookup misses until a result is written.
- R2: A lookup with `lk_dp`=0 for a tag whose low word is held hits and returns that word in `lk_data` bits [DW-1:0], with the upper DW bits zero.
- R3: A write with `wb_dp`=1 fills two latches in one cycle: low word in the older slot, high word in the next slot. A lookup with `lk_dp`=1 hits only while both halves are held and returns {high, low}. Once the low half has been overwritten, both single and double lookups of that tag miss.
- R4: Latches are filled in a circular order that starts at slot 0 after reset. With NLAT latches, a word stays held until NLAT further words have been written, and is then gone.
- R5: A lookup whose tag equals the tag being written in the same cycle (`wb_valid`=1) answers from the write-back inputs. It hits unless it asks for a double and the write is single. In that case it misses, and older held copies of the tag are ignored.
- R6: When `cm_valid` is high, the latches holding `cm_tag` are invalidated at the next edge. A lookup in that same cycle still sees them.
- R7: While `flush` is high, every lookup misses and any write in that cycle is dropped. From the next cycle on, all latches are empty.
- R8: A valid lookup asserts exactly one of `lk_hit` and `lk_wait`. `lk_data` is zero when the lookup misses.
- R9: Writing a tag that is already held invalidates the older copy, so later lookups return the newest value.
- R10: A port with `lk_valid` low drives `lk_hit`, `lk_wait` and `lk_data` to zero.
- R11: Each lookup port resolves its own tag independently of the others in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_valid | input | 1 | Result write this cycle |
| wb_tag | input | TAGW | Reorder-buffer tag of the result |
| wb_dp | input | 1 | Result is double width (two latches) |
| wb_lo | input | DW | Low word of the result |
| wb_hi | input | DW | High word (used when wb_dp=1) |
| cm_valid | input | 1 | A tag retires this cycle |
| cm_tag | input | TAGW | Retiring tag |
| flush | input | 1 | Empty the store |
| lk_valid | input | NLK | Lookup request per port |
| lk_tag | input | NLK*TAGW | Lookup tag per port, port p in bits [p*TAGW +: TAGW] |
| lk_dp | input | NLK | Lookup wants a double-width value |
| lk_hit | output | NLK | Value returned |
| lk_wait | output | NLK | Miss: wait for the second broadcast at retirement |
| lk_data | output | NLK*2*DW | Returned value per port, port p in bits [p*2*DW +: 2*DW] |

## Verification
The bound checker checks on every cycle that hit and wait are mutually exclusive and cover every valid request, and that idle ports stay silent. It also checks that a flush, a reset or a retirement leaves the affected tags missing on the following cycle, and that a same-cycle write answers a matching lookup with its own data. Age-ordered eviction, the split of a double across two slots with loss of its low half, and the replacement of a rewritten tag depend on histories of many writes. Only the bench's sweeps against its reference model show these.

// File: rtl/rlat_cache.sv
module rlat_cache #(
  parameter int NLAT = 8,
  parameter int TAGW = 7,
  parameter int DW   = 32,
  parameter int NLK  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wb_valid,
  input  logic [TAGW-1:0]       wb_tag,
  input  logic                  wb_dp,
  input  logic [DW-1:0]         wb_lo,
  input  logic [DW-1:0]         wb_hi,
  input  logic                  cm_valid,
  input  logic [TAGW-1:0]       cm_tag,
  input  logic                  flush,
  input  logic [NLK-1:0]        lk_valid,
  input  logic [NLK*TAGW-1:0]   lk_tag,
  input  logic [NLK-1:0]        lk_dp,
  output logic [NLK-1:0]        lk_hit,
  output logic [NLK-1:0]        lk_wait,
  output logic [NLK*2*DW-1:0]   lk_data
);
  localparam int PW = (NLAT > 1) ? $clog2(NLAT) : 1;

  logic [NLAT-1:0] v, hf;
  logic [TAGW-1:0] tg [NLAT];
  logic [DW-1:0]   dt [NLAT];
  logic [PW-1:0]   ptr;
  logic [PW-1:0]   ptr1;

  assign ptr1 = ptr + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      v   <= '0;
      ptr <= '0;
    end else if (flush) begin
      v <= '0;
    end else begin
      for (int e = 0; e < NLAT; e++)
        if ((cm_valid && tg[e] == cm_tag) || (wb_valid && tg[e] == wb_tag))
          v[e] <= 1'b0;
      if (wb_valid) begin
        v[ptr]  <= 1'b1;
        tg[ptr] <= wb_tag;
        hf[ptr] <= 1'b0;
        dt[ptr] <= wb_lo;
        if (wb_dp) begin
          v[ptr1]  <= 1'b1;
          tg[ptr1] <= wb_tag;
          hf[ptr1] <= 1'b1;
          dt[ptr1] <= wb_hi;
        end
        ptr <= wb_dp ? ptr + PW'(2) : ptr1;
      end
    end
  end

  for (genvar p = 0; p < NLK; p++) begin : g_port
    logic [TAGW-1:0] t;
    logic            lo_h, hi_h, wm, hit;
    logic [DW-1:0]   lo_d, hi_d;

    assign t  = lk_tag[p*TAGW +: TAGW];
    assign wm = wb_valid && wb_tag == t;

    always_comb begin
      lo_h = 1'b0;
      hi_h = 1'b0;
      lo_d = '0;
      hi_d = '0;
      for (int e = 0; e < NLAT; e++)
        if (v[e] && tg[e] == t) begin
          if (hf[e]) begin
            hi_h = 1'b1;
            hi_d = hi_d | dt[e];
          end else begin
            lo_h = 1'b1;
            lo_d = lo_d | dt[e];
          end
        end
    end

    assign hit = lk_valid[p] && !flush &&
                 (wm ? (!lk_dp[p] || wb_dp) : (lo_h && (!lk_dp[p] || hi_h)));

    assign lk_hit[p]  = hit;
    assign lk_wait[p] = lk_valid[p] && !hit;
    assign lk_data[p*2*DW +: 2*DW] =
      !hit ? '0 :
      wm   ? {(lk_dp[p] ? wb_hi : {DW{1'b0}}), wb_lo} :
             {(lk_dp[p] ? hi_d  : {DW{1'b0}}), lo_d};
  end
endmodule

// File: rtl/rlat_cache_chk.sv
module rlat_cache_chk #(
  parameter int NLAT = 8,
  parameter int TAGW = 7,
  parameter int DW   = 32,
  parameter int NLK  = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                wb_valid,
  input logic [TAGW-1:0]     wb_tag,
  input logic                wb_dp,
  input logic [DW-1:0]       wb_lo,
  input logic                cm_valid,
  input logic [TAGW-1:0]     cm_tag,
  input logic                flush,
  input logic [NLK-1:0]      lk_valid,
  input logic [NLK*TAGW-1:0] lk_tag,
  input logic [NLK-1:0]      lk_dp,
  input logic [NLK-1:0]      lk_hit,
  input logic [NLK-1:0]      lk_wait,
  input logic [NLK*2*DW-1:0] lk_data
);
  for (genvar p = 0; p < NLK; p++) begin : g_chk
    logic [TAGW-1:0] t;
    logic [2*DW-1:0] d;
    assign t = lk_tag[p*TAGW +: TAGW];
    assign d = lk_data[p*2*DW +: 2*DW];

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(lk_hit[p] && lk_wait[p]));
    p_answered_r8: assert property (@(posedge clk) disable iff (rst)
      lk_valid[p] |-> (lk_hit[p] || lk_wait[p]));
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
      lk_wait[p] |-> d == '0);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      !lk_valid[p] |-> (!lk_hit[p] && !lk_wait[p] && d == '0));
    p_flush_miss_r7: assert property (@(posedge clk) disable iff (rst)
      flush |-> !lk_hit[p]);
    p_after_flush_r7: assert property (@(posedge clk) disable iff (rst)
      ($past(flush) && !wb_valid) |-> !lk_hit[p]);
    p_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !wb_valid) |-> !lk_hit[p]);
    p_commit_gone_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(cm_valid && !(wb_valid && wb_tag == cm_tag)) && !wb_valid &&
       t == $past(cm_tag)) |-> !lk_hit[p]);
    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && !flush && lk_valid[p] && t == wb_tag && (!lk_dp[p] || wb_dp))
      |-> (lk_hit[p] && d[DW-1:0] == wb_lo));
  end
endmodule

bind rlat_cache rlat_cache_chk #(.NLAT(NLAT), .TAGW(TAGW), .DW(DW), .NLK(NLK)) u_chk (
  .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_dp(wb_dp),
  .wb_lo(wb_lo), .cm_valid(cm_valid), .cm_tag(cm_tag), .flush(flush),
  .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_dp(lk_dp), .lk_hit(lk_hit),
  .lk_wait(lk_wait), .lk_data(lk_data)
);

// File: tb/sim_rlat_cache.sv
module sim_rlat_cache;
  localparam int NLAT = 4, TAGW = 4, DW = 8, NLK = 2;

  logic clk = 0, rst = 1;
  logic wb_valid = 0, wb_dp = 0, cm_valid = 0, flush = 0;
  logic [TAGW-1:0] wb_tag = '0, cm_tag = '0;
  logic [DW-1:0] wb_lo = '0, wb_hi = '0;
  logic [NLK-1:0] lk_valid = '0, lk_dp = '0, lk_hit, lk_wait;
  logic [NLK*TAGW-1:0] lk_tag = '0;
  logic [NLK*2*DW-1:0] lk_data;

  int errors = 0, checks = 0;

  bit            mv [NLAT];
  bit            mh [NLAT];
  logic [TAGW-1:0] mt [NLAT];
  logic [DW-1:0] md [NLAT];
  int            mptr = 0;

  always #2 clk = ~clk;

  rlat_cache #(.NLAT(NLAT), .TAGW(TAGW), .DW(DW), .NLK(NLK)) u0 (.*);

  function automatic logic [2*DW+1:0] expect_port(int p);
    logic [TAGW-1:0] t;
    bit lo, hi, hit;
    logic [DW-1:0] ld, hd;
    t = lk_tag[p*TAGW +: TAGW];
    lo = 0; hi = 0; ld = '0; hd = '0;
    if (!lk_valid[p]) return '0;
    if (flush) return {1'b0, 1'b1, {2*DW{1'b0}}};
    if (wb_valid && wb_tag == t) begin
      hit = !lk_dp[p] || wb_dp;
      if (!hit) return {1'b0, 1'b1, {2*DW{1'b0}}};
      return {1'b1, 1'b0, (lk_dp[p] ? wb_hi : {DW{1'b0}}), wb_lo};
    end
    for (int e = 0; e < NLAT; e++)
      if (mv[e] && mt[e] == t) begin
        if (mh[e]) begin hi = 1; hd = md[e]; end
        else begin lo = 1; ld = md[e]; end
      end
    hit = lo && (!lk_dp[p] || hi);
    if (!hit) return {1'b0, 1'b1, {2*DW{1'b0}}};
    return {1'b1, 1'b0, (lk_dp[p] ? hd : {DW{1'b0}}), ld};
  endfunction

  task automatic model_edge();
    if (flush) begin
      for (int e = 0; e < NLAT; e++) mv[e] = 0;
      return;
    end
    for (int e = 0; e < NLAT; e++)
      if ((cm_valid && mt[e] == cm_tag) || (wb_valid && mt[e] == wb_tag)) mv[e] = 0;
    if (wb_valid) begin
      mv[mptr] = 1; mh[mptr] = 0; mt[mptr] = wb_tag; md[mptr] = wb_lo;
      if (wb_dp) begin
        mv[(mptr+1)%NLAT] = 1; mh[(mptr+1)%NLAT] = 1;
        mt[(mptr+1)%NLAT] = wb_tag; md[(mptr+1)%NLAT] = wb_hi;
      end
      mptr = (mptr + (wb_dp ? 2 : 1)) % NLAT;
    end
  endtask

  task automatic step(string req);
    logic [2*DW+1:0] exp_v, act_v;
    #1;
    for (int p = 0; p < NLK; p++) begin
      exp_v = expect_port(p);
      act_v = {lk_hit[p], lk_wait[p], lk_data[p*2*DW +: 2*DW]};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s port %0d tag %0d: actual=%h expected=%h", req, p,
                 lk_tag[p*TAGW +: TAGW], act_v, exp_v);
      end
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wb_valid = 0; wb_dp = 0; cm_valid = 0; flush = 0; lk_valid = '0; lk_dp = '0;
  endtask

  task automatic wr(input int t, input bit dp, input int lo, input int hi);
    wb_valid = 1; wb_tag = TAGW'(t); wb_dp = dp; wb_lo = DW'(lo); wb_hi = DW'(hi);
  endtask

  task automatic lk(input int p, input int t, input bit dp);
    lk_valid[p] = 1; lk_tag[p*TAGW +: TAGW] = TAGW'(t); lk_dp[p] = dp;
  endtask

  initial begin
    #(200000*4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int e = 0; e < NLAT; e++) begin mv[e] = 0; mh[e] = 0; mt[e] = '0; md[e] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: empty after reset, all tags, both widths
    for (int t = 0; t < 16; t++) begin lk(0, t, 0); lk(1, t, 1); step("R1"); end

    // R10: idle ports while writing
    wr(3, 0, 8'h11, 0); step("R10");

    // R2 R4 R11: sweep of single writes with age-ordered eviction
    for (int k = 0; k < 12; k++) begin
      wr(k, 0, k*13+5, 0); lk(0, (k+15)%16, 0); lk(1, (k+12)%16, 0); step("R4");
    end
    for (int t = 0; t < 16; t++) begin lk(0, t, 0); lk(1, (t+1)%16, 0); step("R2"); end
    lk(0, 11, 0); lk(1, 2, 0); step("R11");

    // R5: same-cycle bypass, including double-from-single miss
    wr(5, 0, 8'h5a, 0); lk(0, 5, 0); lk(1, 5, 1); step("R5");
    wr(6, 1, 8'h61, 8'h62); lk(0, 6, 1); lk(1, 6, 0); step("R5");

    // R7: flush drops write, misses during and after
    wr(9, 0, 8'h99, 0); flush = 1; lk(0, 6, 1); lk(1, 9, 0); step("R7");
    for (int t = 0; t < 16; t++) begin lk(0, t, 0); lk(1, t, 1); step("R7"); end

    // R3: double write, then eviction of the low half
    wr(2, 1, 8'ha1, 8'hb2); step("R3");
    lk(0, 2, 1); lk(1, 2, 0); step("R3");
    wr(3, 0, 8'h33, 0); lk(0, 2, 1); step("R3");
    wr(4, 0, 8'h44, 0); lk(0, 2, 1); lk(1, 3, 1); step("R3");
    wr(5, 0, 8'h55, 0); lk(0, 2, 1); lk(1, 2, 0); step("R3");
    lk(0, 2, 1); lk(1, 2, 0); step("R3");

    // R6: retirement
    wr(9, 0, 8'h9c, 0); step("R6");
    cm_valid = 1; cm_tag = 9; lk(0, 9, 0); lk(1, 4, 0); step("R6");
    lk(0, 9, 0); lk(1, 4, 0); step("R6");

    // R9: rewrite replaces older copy
    wr(7, 1, 8'h71, 8'h72); step("R9");
    wr(7, 0, 8'h7e, 0); step("R9");
    lk(0, 7, 0); lk(1, 7, 1); step("R9");

    // R8: mixed hit and miss on the same cycle
    lk(0, 7, 0); lk(1, 13, 0); step("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule